// File: doc/BRIEF.md
# UART Register Access Decoder with Divisor Remap

This block sits between a 32-bit register bus and the rest of a UART. Each cycle it takes one access (an address, a write enable, a read enable and write data). It works out which UART register the access targets, raises a single-cycle strobe with byte data towards that register, and returns the register's value on read data. It holds the line-control byte and the two bytes of the baud-rate divisor itself. The transmitter, the receiver and the interrupt logic only see strobes and byte data.

The top bit of the line-control byte selects one of two address maps, and a small two-state machine records which one is active. In state `MAP_DATA`, the data offset reaches the receive buffer on reads and the transmit holding register on writes, and the control offset reaches the interrupt-enable register. In state `MAP_DIVISOR`, the same two offsets reach the low and high divisor bytes. There are two transitions, and both are taken only by a write to the line-control offset. `T_OPEN_DIVISOR` moves from `MAP_DATA` to `MAP_DIVISOR` when written bit 7 is 1. `T_CLOSE_DIVISOR` moves back when written bit 7 is 0. In every other cycle the machine holds its state (`T_HOLD`).

A write to the line-control byte takes effect at the clock edge that ends the write, so the access in the following cycle already uses the new map.

Top module: `uart_reg_decoder`

## Requirements
- R1: After reset, the line-control byte is 0, the divisor is 0, the machine is in `MAP_DATA`, and a read at offset 8Ch returns 0.
- R2: In `MAP_DATA`, a read at offset 80h returns `{24'b0, rx_byte}` and raises `rx_pop` for that access cycle only.
- R3: In `MAP_DATA`, a write at offset 80h raises `tx_push` for that cycle with `tx_byte` = wdata[7:0], and leaves the divisor unchanged.
- R4: In `MAP_DATA`, a write at offset 84h raises `ien_wr` with `ien_byte` = wdata[7:0], and a read at 84h returns `{24'b0, ien_value}`.
- R5: In `MAP_DIVISOR`, an access at offset 84h reads or writes the divisor high byte (`div_value[15:8]`) and never raises `ien_wr`.
- R6: In `MAP_DIVISOR`, an access at offset 80h reads or writes the divisor low byte (`div_value[7:0]`) and never raises `tx_push` or `rx_pop`.
- R7: Offset 8Ch is the line-control byte. It is readable and writable, it is visible on `line_ctrl`, and bit 7 selects the map (1 = `MAP_DIVISOR`).
- R8: Bits 31:8 of read data are always 0, and bits 31:8 of write data never reach any stored byte.
- R9: An access to any other offset reads 0, raises no strobe and changes no stored byte.
- R10: A write to offset 8Ch changes the map used by the very next access cycle.
- R11: When both enables are high, the access is treated as a write only: no `rx_pop`, and read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write access this cycle |
| rd_en | input | 1 | Read access this cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the access cycle |
| rx_byte | input | 8 | Head of the receive buffer |
| rx_pop | output | 1 | One-cycle pop to the receive buffer |
| tx_push | output | 1 | One-cycle load of the transmit holding register |
| tx_byte | output | 8 | Byte for the transmitter |
| ien_value | input | 8 | Current interrupt-enable byte |
| ien_wr | output | 1 | One-cycle write to the interrupt-enable register |
| ien_byte | output | 8 | Byte for the interrupt-enable register |
| line_ctrl | output | 8 | Line-control byte |
| div_value | output | 16 | Baud divisor, high byte above low byte |

## Verification
On every cycle, the assertions check the following:
- At most one target strobe is high.
- No data-path strobe is raised while the divisor map is active.
- The upper 24 bits of read data are zero.
- Stored bytes stay unchanged in any cycle without a write.
- The line-control byte and the map state follow each write to 8Ch.

Only the bench scenarios can show the following:
- Which register's value is returned for each offset and map.
- That the divisor bytes land in the right halves.
- That the map switches exactly at the access after the control write.
- That unmapped offsets and combined read/write accesses have no visible effect.

// File: rtl/uart_reg_decoder_pkg.sv
package uart_reg_decoder_pkg;

    typedef enum logic {
        MAP_DATA    = 1'b0,
        MAP_DIVISOR = 1'b1
    } map_state_e;

    typedef enum logic [2:0] {
        TGT_NONE   = 3'd0,
        TGT_FIFO   = 3'd1,
        TGT_IEN    = 3'd2,
        TGT_DIV_LO = 3'd3,
        TGT_DIV_HI = 3'd4,
        TGT_LINE   = 3'd5
    } target_e;

endpackage

// File: rtl/uart_map_fsm.sv
module uart_map_fsm
    import uart_reg_decoder_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_wr,
    input  logic sel_bit,
    output logic divisor_map
);

    map_state_e state_q, state_d;

    // next state: T_OPEN_DIVISOR, T_CLOSE_DIVISOR, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_DATA:    if (line_wr && sel_bit)  state_d = MAP_DIVISOR;
            MAP_DIVISOR: if (line_wr && !sel_bit) state_d = MAP_DATA;
            default:     state_d = MAP_DATA;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MAP_DATA;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MAP_DIVISOR: divisor_map = 1'b1;
            default:     divisor_map = 1'b0;
        endcase
    end

    AST_MAP_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        line_wr |=> (divisor_map == $past(sel_bit))) else $error("map state mismatch"); // R10

    AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !line_wr |=> $stable(divisor_map)) else $error("map changed without write"); // R7

endmodule

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
    import uart_reg_decoder_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFF_DATA = 8'h80,
    parameter logic [ADDR_W-1:0] OFF_CTRL = 8'h84,
    parameter logic [ADDR_W-1:0] OFF_LINE = 8'h8C
)(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              divisor_map,
    output target_e           target,
    output logic              is_write,
    output logic              is_read
);

    always_comb begin
        is_write = wr_en;
        is_read  = rd_en && !wr_en;
        target   = TGT_NONE;
        if (wr_en || rd_en) begin
            if (addr == OFF_LINE)      target = TGT_LINE;
            else if (addr == OFF_DATA) target = divisor_map ? TGT_DIV_LO : TGT_FIFO;
            else if (addr == OFF_CTRL) target = divisor_map ? TGT_DIV_HI : TGT_IEN;
        end
    end

endmodule

// File: rtl/uart_divisor_latch.sv
module uart_divisor_latch #(
    parameter int REG_W = 8,
    localparam int DIV_W = 2 * REG_W
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wbyte,
    output logic [DIV_W-1:0] div_value
);

    logic [REG_W-1:0] byte_q [2];
    logic [1:0]       wr_sel;

    assign wr_sel = {wr_hi, wr_lo};

    for (genvar i = 0; i < 2; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         byte_q[i] <= '0;
            else if (wr_sel[i]) byte_q[i] <= wbyte;
        end
        assign div_value[i*REG_W +: REG_W] = byte_q[i];
    end

    AST_DIV_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo && wr_hi)) else $error("two divisor writes"); // R5

    AST_DIV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo || wr_hi) |=> $stable(div_value)) else $error("divisor drift"); // R9

endmodule

// File: rtl/uart_read_mux.sv
module uart_read_mux
    import uart_reg_decoder_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 8,
    localparam int DIV_W = 2 * REG_W
)(
    input  target_e           target,
    input  logic              is_read,
    input  logic [REG_W-1:0]  rx_byte,
    input  logic [REG_W-1:0]  ien_value,
    input  logic [REG_W-1:0]  line_ctrl,
    input  logic [DIV_W-1:0]  div_value,
    output logic [DATA_W-1:0] rdata
);

    logic [REG_W-1:0] sel_byte;

    always_comb begin
        sel_byte = '0;
        if (is_read) begin
            unique case (target)
                TGT_FIFO:   sel_byte = rx_byte;
                TGT_IEN:    sel_byte = ien_value;
                TGT_DIV_LO: sel_byte = div_value[REG_W-1:0];
                TGT_DIV_HI: sel_byte = div_value[DIV_W-1:REG_W];
                TGT_LINE:   sel_byte = line_ctrl;
                default:    sel_byte = '0;
            endcase
        end
        rdata = {{(DATA_W-REG_W){1'b0}}, sel_byte};
    end

endmodule

// File: rtl/uart_reg_decoder.sv
module uart_reg_decoder
    import uart_reg_decoder_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int REG_W  = 8,
    parameter logic [ADDR_W-1:0] OFF_DATA = 8'h80,
    parameter logic [ADDR_W-1:0] OFF_CTRL = 8'h84,
    parameter logic [ADDR_W-1:0] OFF_LINE = 8'h8C,
    localparam int DIV_W = 2 * REG_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [REG_W-1:0]  rx_byte,
    output logic              rx_pop,
    output logic              tx_push,
    output logic [REG_W-1:0]  tx_byte,
    input  logic [REG_W-1:0]  ien_value,
    output logic              ien_wr,
    output logic [REG_W-1:0]  ien_byte,
    output logic [REG_W-1:0]  line_ctrl,
    output logic [DIV_W-1:0]  div_value
);

    target_e          target;
    logic             is_write, is_read;
    logic             divisor_map;
    logic             line_wr;
    logic [REG_W-2:0] line_low_q;
    logic [REG_W-1:0] wbyte;

    assign wbyte = wdata[REG_W-1:0];

    uart_addr_decode #(
        .ADDR_W(ADDR_W), .OFF_DATA(OFF_DATA), .OFF_CTRL(OFF_CTRL), .OFF_LINE(OFF_LINE)
    ) u_decode (
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .divisor_map(divisor_map),
        .target(target), .is_write(is_write), .is_read(is_read)
    );

    assign line_wr = is_write && (target == TGT_LINE);

    uart_map_fsm u_map (
        .clk(clk), .rst_n(rst_n), .line_wr(line_wr),
        .sel_bit(wbyte[REG_W-1]), .divisor_map(divisor_map)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       line_low_q <= '0;
        else if (line_wr) line_low_q <= wbyte[REG_W-2:0];
    end

    assign line_ctrl = {divisor_map, line_low_q};

    uart_divisor_latch #(.REG_W(REG_W)) u_div (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(is_write && (target == TGT_DIV_LO)),
        .wr_hi(is_write && (target == TGT_DIV_HI)),
        .wbyte(wbyte), .div_value(div_value)
    );

    always_comb begin
        tx_push = is_write && (target == TGT_FIFO);
        rx_pop  = is_read  && (target == TGT_FIFO);
        ien_wr  = is_write && (target == TGT_IEN);
    end

    assign tx_byte  = wbyte;
    assign ien_byte = wbyte;

    uart_read_mux #(.DATA_W(DATA_W), .REG_W(REG_W)) u_rmux (
        .target(target), .is_read(is_read), .rx_byte(rx_byte), .ien_value(ien_value),
        .line_ctrl(line_ctrl), .div_value(div_value), .rdata(rdata)
    );

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_push, rx_pop, ien_wr})) else $error("strobe overlap"); // R11

    AST_NO_POP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rx_pop) else $error("pop during write"); // R11

    AST_DIVMAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctrl[REG_W-1] |-> !(tx_push || rx_pop || ien_wr)) else $error("data strobe in divisor map"); // R6

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:REG_W] == '0) else $error("upper read bits set"); // R8

    AST_LINE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_LINE) |=> line_ctrl == $past(wdata[REG_W-1:0])) else $error("line byte load"); // R7

    AST_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(line_ctrl)) else $error("line byte drift"); // R9

endmodule

// File: tb/uart_reg_decoder_bench.sv
module uart_reg_decoder_bench;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  rx_byte = 8'hA5;
    logic        rx_pop, tx_push, ien_wr;
    logic [7:0]  tx_byte, ien_byte, line_ctrl;
    logic [7:0]  ien_value = 8'h3C;
    logic [15:0] div_value;

    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_reg_decoder u_uart_reg_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte), .rx_pop(rx_pop),
        .tx_push(tx_push), .tx_byte(tx_byte), .ien_value(ien_value), .ien_wr(ien_wr),
        .ien_byte(ien_byte), .line_ctrl(line_ctrl), .div_value(div_value)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one access at the falling edge, sample mid-cycle, complete at the rising edge.
    logic [31:0] s_rdata;
    logic        s_pop, s_push, s_ien;
    logic [7:0]  s_txb, s_ienb;

    task automatic access(input logic [7:0] a, input bit w, input bit r, input logic [31:0] d);
        addr = a; wr_en = w; rd_en = r; wdata = d;
        #(CLK_PERIOD/4);
        s_rdata = rdata; s_pop = rx_pop; s_push = tx_push; s_ien = ien_wr;
        s_txb = tx_byte; s_ienb = ien_byte;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    endtask

    task automatic idle_check_quiet(input string req);
        #(CLK_PERIOD/4);
        chk(!rx_pop && !tx_push && !ien_wr, req, {rx_pop, tx_push, ien_wr}, 0);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(line_ctrl == 8'h00, "R1 line", line_ctrl, 0);
        chk(div_value == 16'h0, "R1 div", div_value, 0);
        access(8'h8C, 0, 1, 0);
        chk(s_rdata == 0, "R1 read 8C", s_rdata, 0);
    endtask

    task automatic t_data_map;
        access(8'h80, 0, 1, 0);
        chk(s_rdata == 32'h0000_00A5 && s_pop, "R2 rx read", {s_pop, s_rdata[30:0]}, 32'h8000_00A5);
        idle_check_quiet("R2 pop one cycle");
        access(8'h80, 1, 0, 32'hFFFF_FF5A);
        chk(s_push && s_txb == 8'h5A, "R3 push", {s_push, s_txb}, {1'b1, 8'h5A});
        chk(div_value == 16'h0, "R3 divisor untouched", div_value, 0);
        access(8'h84, 1, 0, 32'h0000_0017);
        chk(s_ien && s_ienb == 8'h17 && !s_push, "R4 ien write", {s_ien, s_ienb}, {1'b1, 8'h17});
        access(8'h84, 0, 1, 0);
        chk(s_rdata == 32'h3C && !s_pop, "R4 ien read", s_rdata, 32'h3C);
    endtask

    task automatic t_line_ctrl;
        access(8'h8C, 1, 0, 32'hABCD_EF83);
        chk(line_ctrl == 8'h83, "R7 line store", line_ctrl, 8'h83);
        access(8'h8C, 0, 1, 0);
        chk(s_rdata == 32'h83, "R8 upper ignored", s_rdata, 32'h83);
    endtask

    task automatic t_divisor_map;
        access(8'h80, 1, 0, 32'hFFFF_FF12);
        chk(!s_push && div_value == 16'h0012, "R6 low byte write", {s_push, div_value}, 17'h00012);
        access(8'h84, 1, 0, 32'h5555_5534);
        chk(!s_ien && div_value == 16'h3412, "R5 high byte write", {s_ien, div_value}, 17'h03412);
        access(8'h80, 0, 1, 0);
        chk(s_rdata == 32'h12 && !s_pop, "R6 low byte read", s_rdata, 32'h12);
        access(8'h84, 0, 1, 0);
        chk(s_rdata == 32'h34, "R5 high byte read", s_rdata, 32'h34);
    endtask

    task automatic t_switch_timing;
        access(8'h8C, 1, 0, 32'h03);
        access(8'h80, 1, 0, 32'h66);
        chk(s_push && div_value == 16'h3412, "R10 close then push", {s_push, div_value}, 17'h13412);
        access(8'h8C, 1, 0, 32'h80);
        access(8'h84, 1, 0, 32'h99);
        chk(!s_ien && div_value == 16'h9912, "R10 open then high byte", {s_ien, div_value}, 17'h09912);
        access(8'h8C, 1, 0, 32'h00);
    endtask

    task automatic t_unmapped;
        access(8'h88, 1, 0, 32'hFF);
        chk(!s_push && !s_ien && !s_pop, "R9 write 88 strobes", {s_push, s_ien, s_pop}, 0);
        chk(line_ctrl == 8'h00 && div_value == 16'h9912, "R9 state kept", {line_ctrl, div_value}, 24'h009912);
        access(8'h90, 0, 1, 0);
        chk(s_rdata == 0 && !s_pop, "R9 read 90", s_rdata, 0);
    endtask

    task automatic t_both_enables;
        access(8'h80, 1, 1, 32'h44);
        chk(s_push && !s_pop && s_rdata == 0, "R11 write wins", {s_push, s_pop, s_rdata[29:0]}, 32'h8000_0000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_map();
        t_line_ctrl();
        t_divisor_map();
        t_switch_timing();
        t_unmapped();
        t_both_enables();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule